// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Port

This block is a byte-oriented asynchronous serial port. Software reaches it through a small register bus with two locations: a control/status register and a data location. Writing the data location loads a separate transmit register and launches a frame on the TX pin. Reading it returns the last byte that the receiver accepted. The control register picks one of three active frame formats. The first is a ten-bit frame timed by an external baud tick. The second is an eleven-bit frame whose bit period is a fixed count of system clocks. The third is an eleven-bit frame timed by the external tick. In the eleven-bit formats, software supplies the ninth transmitted bit and reads back the ninth received bit. The remaining encoding is a synchronous shift mode, which this block does not implement; in that encoding the port stays idle.

A filter bit in the control register changes what the receiver accepts. In the eleven-bit formats it drops every frame whose ninth bit is 0, so a node on a shared line wakes only for address frames. In the ten-bit format it drops frames with a bad stop bit. A separate select input turns the top control bit into a sticky framing-error flag. While that input is high, writes to the bit can only clear the flag and leave the mode as it was. The transmit-done flag and the receive flag are ORed onto one interrupt line.

Top module: `sport_top`

## Requirements
- R1: After reset the control register reads 0x00, the receive buffer reads 0x00, `txd` is high and `irq` is low.
- R2: Control bits [7:6] give the mode. 01 and 11 use 16 `baud_tick` pulses per bit. 10 uses 64 clocks per bit, or 32 when `dbl_rate` is 1.
- R3: A frame on `txd` has a low start bit, then eight data bits least-significant first, then control bit 3 as the ninth bit in modes 10 and 11 only, then a high stop bit. The line is high when idle.
- R4: The TX flag (control bit 1) sets when the last data bit ends and stays set until software writes 0 to it.
- R5: In mode 01 with the filter bit (control bit 5) clear, a received frame loads the buffer, copies its stop bit into control bit 2 and sets the RX flag (control bit 0) after the stop bit is sampled.
- R6: In mode 01 with the filter bit set, a frame whose stop bit is low leaves the buffer, bit 2 and the RX flag unchanged.
- R7: In modes 10 and 11, the ninth received bit goes to control bit 2 and the RX flag sets after that bit is sampled. With the filter bit set, a frame whose ninth bit is 0 leaves the buffer, bit 2 and the RX flag unchanged.
- R8: While control bit 4 (receive enable) is 0, no frame is received.
- R9: While `fe_sel` is 1, control bit 7 reads a flag that sets when a stop bit samples low. Writing 0 clears the flag, writing 1 leaves it, and neither changes the mode.
- R10: If a flag is set by the port in the same cycle that software writes the control register, the set wins.
- R11: `irq` is high exactly when the TX flag or the RX flag is set.
- R12: In mode 00 a buffer write sends no frame and the receiver accepts nothing.
- R13: A low pulse on `rxd` that is back high by mid-bit is rejected as noise and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects the control register, 1 the data buffer |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| baud_tick | input | 1 | External oversampling tick, 16 per bit |
| dbl_rate | input | 1 | Halves the fixed bit period of mode 10 |
| fe_sel | input | 1 | Makes control bit 7 the framing-error flag |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt, OR of the TX and RX flags |

## Verification
The port sets the RX flag in one cycle, and a software write to the control register can land in that same cycle with a 0 in the flag position. To provoke the clash, the bench drives a full frame while it holds a write of the control register, with the RX flag at 0, on every clock. It does not need to know the exact cycle. The correct result is that the flag reads 1 for exactly one sampled cycle: the port's set must win on the first edge, and the write clears the flag on the next edge. If the write won instead, the flag would never be seen.

// File: rtl/sport_pkg.sv
`timescale 1ns/1ps
package sport_pkg;

  typedef enum logic [1:0] {
    MD_SHIFT   = 2'b00,
    MD_TEN     = 2'b01,
    MD_FIXED11 = 2'b10,
    MD_TICK11  = 2'b11
  } sport_mode_e;

  function automatic logic has_ninth(sport_mode_e m);
    return (m == MD_FIXED11) || (m == MD_TICK11);
  endfunction

  function automatic logic is_active(sport_mode_e m);
    return m != MD_SHIFT;
  endfunction

  function automatic logic vote3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // A frame is kept unless the filter is on and the qualifying bit is low
  function automatic logic frame_keep(logic filt, logic qual);
    return !filt || qual;
  endfunction

  function automatic logic [10:0] build_frame(sport_mode_e m, logic [7:0] d, logic b9);
    return has_ninth(m) ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
  endfunction

endpackage

// File: rtl/sport_tick.sv
`timescale 1ns/1ps
module sport_tick
  import sport_pkg::*;
#(
  parameter int CLK_PER_BIT = 64,
  parameter int OSR         = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  sport_mode_e mode,
  input  logic        ext_tick,
  input  logic        dbl,
  output logic        tick
);
  localparam int DIV_SLOW = CLK_PER_BIT / OSR;
  localparam int DIV_FAST = (DIV_SLOW / 2 > 0) ? DIV_SLOW / 2 : 1;
  localparam int CW       = $clog2(DIV_SLOW + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          fix_hit;

  assign lim     = dbl ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
  assign fix_hit = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cnt <= '0;
    else if (mode != MD_FIXED11 || fix_hit)   cnt <= '0;
    else                                      cnt <= cnt + 1'b1;
  end

  always_comb begin
    case (mode)
      MD_TEN, MD_TICK11: tick = ext_tick;
      MD_FIXED11:        tick = fix_hit;
      default:           tick = 1'b0;
    endcase
  end

  AST_FIXED_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_FIXED11 && tick && !dbl) |=> !tick); // R2

endmodule

// File: rtl/sport_tx.sv
`timescale 1ns/1ps
module sport_tx
  import sport_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  sport_mode_e mode,
  input  logic        start,
  input  logic [7:0]  data,
  input  logic        bit9,
  output logic        txd,
  output logic        busy,
  output logic        ti_set
);
  localparam int OCW = $clog2(OSR);

  logic [10:0]    shreg;
  logic [OCW-1:0] ocnt;
  logic [3:0]     idx;
  logic [3:0]     last;
  logic           bit_end;
  logic           launch;

  assign launch  = start && !busy && is_active(mode);
  assign bit_end = busy && tick && (ocnt == OCW'(OSR - 1));
  assign ti_set  = bit_end && (idx == last - 4'd1);
  assign txd     = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      ocnt  <= '0;
      idx   <= '0;
      last  <= '0;
      busy  <= 1'b0;
    end else if (launch) begin
      shreg <= build_frame(mode, data, bit9);
      last  <= has_ninth(mode) ? 4'd10 : 4'd9;
      idx   <= '0;
      ocnt  <= '0;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (bit_end) begin
        ocnt  <= '0;
        shreg <= {1'b1, shreg[10:1]};
        if (idx == last) busy <= 1'b0;
        else             idx  <= idx + 4'd1;
      end else begin
        ocnt <= ocnt + 1'b1;
      end
    end
  end

  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R3
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R3
  AST_TX_QUIET_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SHIFT && !busy) |=> !busy); // R12

endmodule

// File: rtl/sport_rx.sv
`timescale 1ns/1ps
module sport_rx
  import sport_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  sport_mode_e mode,
  input  logic        ren,
  input  logic        filt,
  input  logic        rxd,
  output logic        load,
  output logic [7:0]  load_data,
  output logic        load_b8,
  output logic        ri_set,
  output logic        fe_set
);
  localparam int OCW = $clog2(OSR);
  localparam int MID = OSR / 2;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP} rx_state_e;

  rx_state_e      state;
  logic           rx_m, rx_s;
  logic [OCW-1:0] ocnt;
  logic [2:0]     bcnt;
  logic [7:0]     shreg;
  logic           s_a, s_b;
  logic           vote;
  logic           bit_ev, ninth_ev, stop_ev, keep;

  assign vote     = vote3(s_a, s_b, rx_s);
  assign bit_ev   = tick && (state != RX_IDLE) && (ocnt == OCW'(MID + 1));
  assign ninth_ev = bit_ev && (state == RX_NINTH);
  assign stop_ev  = bit_ev && (state == RX_STOP);
  assign keep     = frame_keep(filt, vote);

  always_comb begin
    load      = 1'b0;
    load_data = shreg;
    load_b8   = vote;
    if (ninth_ev)                       load = keep;
    else if (stop_ev && mode == MD_TEN) load = keep;
    ri_set = load;
    fe_set = stop_ev && !vote;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      ocnt  <= '0;
      bcnt  <= '0;
      shreg <= '0;
      s_a   <= 1'b1;
      s_b   <= 1'b1;
    end else if (!ren || !is_active(mode)) begin
      state <= RX_IDLE;
    end else if (state == RX_IDLE) begin
      if (tick && !rx_s) begin
        state <= RX_START;
        ocnt  <= OCW'(1);
        bcnt  <= '0;
      end
    end else if (tick) begin
      ocnt <= (ocnt == OCW'(OSR - 1)) ? '0 : ocnt + 1'b1;
      if (ocnt == OCW'(MID - 1)) s_a <= rx_s;
      if (ocnt == OCW'(MID))     s_b <= rx_s;
      if (bit_ev) begin
        case (state)
          RX_START: state <= vote ? RX_IDLE : RX_DATA;
          RX_DATA: begin
            shreg <= {vote, shreg[7:1]};
            bcnt  <= bcnt + 3'd1;
            if (bcnt == 3'd7) state <= has_ninth(mode) ? RX_NINTH : RX_STOP;
          end
          RX_NINTH: state <= RX_STOP;
          default:  state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RI_NEEDS_REN: assert property (@(posedge clk) disable iff (!rst_n)
    ri_set |-> (ren && is_active(mode))); // R8
  AST_FILTER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ninth_ev && filt && !vote) |-> !ri_set); // R7

endmodule

// File: rtl/sport_top.sv
`timescale 1ns/1ps
module sport_top
  import sport_pkg::*;
#(
  parameter int CLK_PER_BIT = 64,
  parameter int OSR         = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       baud_tick,
  input  logic       dbl_rate,
  input  logic       fe_sel,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  logic        mode_hi, mode_lo, filt, ren, tb8, rb8, ti, ri, fe;
  logic [7:0]  rxbuf;
  logic        wr_ctrl, wr_buf;
  logic        tick, tx_busy, ti_set;
  logic        rx_load, rx_b8, ri_set, fe_set;
  logic [7:0]  rx_data;
  sport_mode_e mode;

  assign wr_ctrl = wr_en && !reg_sel;
  assign wr_buf  = wr_en &&  reg_sel;
  assign mode    = sport_mode_e'({mode_hi, mode_lo});

  sport_tick #(.CLK_PER_BIT(CLK_PER_BIT), .OSR(OSR)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ext_tick(baud_tick),
    .dbl(dbl_rate), .tick(tick));

  sport_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .start(wr_buf),
    .data(wr_data), .bit9(tb8), .txd(txd), .busy(tx_busy), .ti_set(ti_set));

  sport_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .ren(ren),
    .filt(filt), .rxd(rxd), .load(rx_load), .load_data(rx_data),
    .load_b8(rx_b8), .ri_set(ri_set), .fe_set(fe_set));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {mode_hi, mode_lo, filt, ren, tb8} <= '0;
    end else if (wr_ctrl) begin
      if (!fe_sel) mode_hi <= wr_data[7];
      mode_lo <= wr_data[6];
      filt    <= wr_data[5];
      ren     <= wr_data[4];
      tb8     <= wr_data[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ti    <= 1'b0;
      ri    <= 1'b0;
      rb8   <= 1'b0;
      fe    <= 1'b0;
      rxbuf <= '0;
    end else begin
      ti <= ti_set | (wr_ctrl ? wr_data[1] : ti);
      ri <= ri_set | (wr_ctrl ? wr_data[0] : ri);
      if (rx_load)      rb8 <= rx_b8;
      else if (wr_ctrl) rb8 <= wr_data[2];
      if (fe_set)                                  fe <= 1'b1;
      else if (wr_ctrl && fe_sel && !wr_data[7])   fe <= 1'b0;
      if (rx_load) rxbuf <= rx_data;
    end
  end

  assign rd_data = reg_sel ? rxbuf
                           : {(fe_sel ? fe : mode_hi), mode_lo, filt, ren, tb8, rb8, ti, ri};
  assign irq     = ti | ri;

  AST_RI_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ri_set |=> ri); // R10
  AST_TI_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ti_set |=> ti); // R4
  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !(wr_ctrl && fe_sel && !wr_data[7])) |=> fe); // R9
  AST_MODE_KEPT_UNDER_FE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && fe_sel) |=> $stable(mode_hi)); // R9

endmodule

// File: tb/sport_top_tb.sv
`timescale 1ns/1ps
module sport_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       baud_tick = 1'b0;
  logic       dbl_rate = 1'b0;
  logic       fe_sel = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [1:0] bcnt = '0;

  sport_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .baud_tick(baud_tick),
    .dbl_rate(dbl_rate), .fe_sel(fe_sel), .rxd(rxd), .txd(txd), .irq(irq));

  always #2 clk = ~clk;

  // one baud tick every 4 clocks: 64 clocks per bit in the tick-timed modes
  always @(posedge clk) begin
    bcnt      <= bcnt + 2'd1;
    baud_tick <= (bcnt == 2'd3);
  end

  typedef struct packed {
    logic [1:0] mode;
    logic       sm2;
    logic       dbl;
    logic [7:0] data;
    logic       b9;
    logic       stp;
    logic       ri;
    logic       rb8;
    logic       ld;
  } rxv_t;

  localparam rxv_t RXV [9] = '{
    '{2'b01, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{2'b01, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'b01, 1'b1, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'b01, 1'b1, 1'b0, 8'hC3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{2'b10, 1'b0, 1'b0, 8'h81, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{2'b10, 1'b1, 1'b1, 8'h7E, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'b10, 1'b1, 1'b1, 8'h42, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{2'b11, 1'b0, 1'b0, 8'h99, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{2'b11, 1'b1, 1'b0, 8'h18, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1 v = rd_data;
    reg_sel = 1'b0;
  endtask

  task automatic send_rx(input logic nine, input logic [7:0] d, input logic b9,
                         input logic stp, input int bitclk);
    logic [10:0] f;
    int n;
    f = nine ? {stp, b9, d, 1'b0} : {1'b1, stp, d, 1'b0};
    n = nine ? 11 : 10;
    for (int i = 0; i < n; i++) begin
      rxd = f[i];
      repeat (bitclk) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic cap_tx(input int bitclk, input int nb, output logic [10:0] v,
                        output logic ti_last, output logic ti_stop);
    int w;
    v = '0; ti_last = 1'bx; ti_stop = 1'bx; w = 0;
    while (txd === 1'b1 && w < 400) begin @(negedge clk); w++; end
    repeat (bitclk / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      v[i] = txd;
      if (i == nb - 2) ti_last = rd_data[1];
      if (i == nb - 1) ti_stop = rd_data[1];
      if (i < nb - 1) repeat (bitclk) @(negedge clk);
    end
    repeat (bitclk) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [7:0]  exp_buf;
    logic [10:0] fr;
    logic        tl, ts;
    int          seen;
    rxv_t        e;

    repeat (5) @(negedge clk);
    // R1 reset state, sampled before release
    rd(1'b0, v); chk("R1 control at reset", v, 8'h00);
    rd(1'b1, v); chk("R1 buffer at reset", v, 8'h00);
    chk("R1 txd at reset", txd, 1'b1);
    chk("R1 irq at reset", irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_buf = 8'h00;

    // Table walk: R2 R5 R6 R7 R11 receive vectors
    for (int k = 0; k < 9; k++) begin
      e = RXV[k];
      dbl_rate = e.dbl;
      wr(1'b0, {e.mode, e.sm2, 1'b1, 4'b0000});
      send_rx(e.mode[1], e.data, e.b9, e.stp, e.dbl ? 32 : 64);
      repeat (20) @(negedge clk);
      rd(1'b0, v);
      chk("R5 R6 R7 table RX flag", v[0], e.ri);
      chk("R5 R6 R7 table ninth/stop bit", v[2], e.rb8);
      chk("R11 table irq", irq, e.ri);
      if (e.ld) exp_buf = e.data;
      rd(1'b1, v);
      chk("R5 R6 R7 R2 table buffer", v, exp_buf);
    end
    dbl_rate = 1'b0;

    // R3 R4 R11: mode 01 transmit
    wr(1'b0, 8'h40);
    wr(1'b1, 8'hB2);
    cap_tx(64, 10, fr, tl, ts);
    chk("R3 mode01 frame", fr[9:0], {1'b1, 8'hB2, 1'b0});
    chk("R4 TX flag during last data bit", tl, 1'b0);
    chk("R4 TX flag during stop bit", ts, 1'b1);
    chk("R11 irq from TX flag", irq, 1'b1);
    repeat (100) @(negedge clk);
    rd(1'b0, v); chk("R4 TX flag held", v[1], 1'b1);
    wr(1'b0, 8'h40);
    rd(1'b0, v); chk("R4 TX flag cleared by write", v[1], 1'b0);
    chk("R11 irq low with both flags clear", irq, 1'b0);

    // R2 R3: mode 10 at double rate with ninth bit 1
    dbl_rate = 1'b1;
    wr(1'b0, 8'h88);
    wr(1'b1, 8'h6D);
    cap_tx(32, 11, fr, tl, ts);
    chk("R2 R3 mode10 fast frame", fr, {1'b1, 1'b1, 8'h6D, 1'b0});
    dbl_rate = 1'b0;

    // R3: mode 11 with ninth bit 0
    wr(1'b0, 8'hC0);
    wr(1'b1, 8'hE4);
    cap_tx(64, 11, fr, tl, ts);
    chk("R3 mode11 frame", fr, {1'b1, 1'b0, 8'hE4, 1'b0});
    wr(1'b0, 8'h00);

    // R12: shift mode sends and receives nothing
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h0F);
    seen = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!txd) seen++; end
    chk("R12 no frame in mode 00", seen, 0);
    send_rx(1'b0, 8'h77, 1'b0, 1'b1, 64);
    repeat (20) @(negedge clk);
    rd(1'b0, v); chk("R12 no RX flag in mode 00", v[0], 1'b0);

    // R8: receiver disabled
    wr(1'b0, 8'h40);
    send_rx(1'b0, 8'h66, 1'b0, 1'b1, 64);
    repeat (20) @(negedge clk);
    rd(1'b0, v); chk("R8 no RX flag with receiver off", v[0], 1'b0);
    rd(1'b1, v); chk("R8 buffer unchanged with receiver off", v, exp_buf);

    // R13: short low glitch
    wr(1'b0, 8'h50);
    @(negedge clk); rxd = 1'b0;
    repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (1000) @(negedge clk);
    rd(1'b0, v); chk("R13 glitch gives no RX flag", v[0], 1'b0);
    rd(1'b1, v); chk("R13 glitch leaves buffer", v, exp_buf);

    // R9: framing-error flag on bit 7
    fe_sel = 1'b1;
    wr(1'b0, 8'h50);
    rd(1'b0, v); chk("R9 flag cleared by write of 0", v[7], 1'b0);
    send_rx(1'b0, 8'h24, 1'b0, 1'b0, 64);
    repeat (20) @(negedge clk);
    exp_buf = 8'h24;
    rd(1'b0, v); chk("R9 flag set by low stop", v[7], 1'b1);
    wr(1'b0, 8'hD0);
    rd(1'b0, v); chk("R9 write of 1 keeps flag", v[7], 1'b1);
    fe_sel = 1'b0;
    rd(1'b0, v); chk("R9 mode bit untouched by flag writes", v[7], 1'b0);
    fe_sel = 1'b1;
    wr(1'b0, 8'h50);
    rd(1'b0, v); chk("R9 flag cleared again", v[7], 1'b0);
    fe_sel = 1'b0;

    // R10: RX flag set against a control write every cycle
    wr(1'b0, 8'h50);
    seen = 0;
    fork
      send_rx(1'b0, 8'hA1, 1'b0, 1'b1, 64);
      begin
        @(negedge clk);
        reg_sel = 1'b0; wr_en = 1'b1; wr_data = 8'h50;
        for (int i = 0; i < 760; i++) begin
          @(negedge clk);
          if (rd_data[0]) seen++;
        end
        wr_en = 1'b0;
      end
    join
    chk("R10 RX flag visible for one cycle under writes", seen, 1);
    rd(1'b1, v); chk("R10 buffer loaded under writes", v, 8'hA1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule